// File: doc/BRIEF.md
# Rotating Register Renamer for Software-Pipelined Loops

This block maps logical register numbers to physical register numbers for three register classes: general, floating-point and predicate. Each class has a rotating region. A logical number inside that region is offset by a per-class rotating base, modulo the region size. A logical number outside the region passes through unchanged.

Every taken loop-closing branch decrements all three bases together at the same clock edge. After that edge, the value an iteration wrote into logical register r is visible to the next iteration as logical register r+1. The register at the top of each region wraps to the bottom.

The general-register region starts at 32 and its size can be programmed. The floating-point region is fixed at registers 32 to 127. The predicate region is fixed at registers 16 to 63. The mapping outputs are combinational from the current bases. The strobes take effect at the next rising clock edge.

Top module: `rot_rename`

## Requirements
- R1: A logical number below its class's region start passes through unchanged, as does a general number at or above 32 + size. The region start is 32 for general and floating-point registers and 16 for predicate registers.
- R2: A logical number r inside a region maps to lo + ((r − lo + base) mod size), where lo is the region start and base is that class's rotating base.
- R3: On a clock edge with `loop_br` high and `rrb_clear` low, every class base with a nonzero region size becomes base − 1. A base of 0 wraps to size − 1. As a result, logical r+1 maps afterwards to the physical register that logical r mapped to before.
- R4: `rrb_clear` sets all three bases to zero at the next edge, and it overrides `loop_br` in the same cycle.
- R5: `gr_size_wr` loads the general region size from `gr_size_in` and clears the general base. Values above 96 are clamped to 96. The other two classes still rotate if `loop_br` is high in the same cycle.
- R6: The floating-point region has size 96 and the predicate region has size 48. Both rotate on the same edge as the general region.
- R7: With a general region size of 0, general numbers are never renamed, even when `loop_br` is high.
- R8: After reset, all bases are zero and the general region size is 0, so every mapping is the identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_br | input | 1 | Loop-closing branch taken; rotate all classes |
| rrb_clear | input | 1 | Zero all rotating bases |
| gr_size_wr | input | 1 | Load a new general region size |
| gr_size_in | input | 7 | New general region size |
| gr_lreg | input | 7 | Logical general register number |
| fr_lreg | input | 7 | Logical floating-point register number |
| pr_lreg | input | 6 | Logical predicate register number |
| gr_preg | output | 7 | Physical general register number |
| fr_preg | output | 7 | Physical floating-point register number |
| pr_preg | output | 6 | Physical predicate register number |

## Verification
The assertions check four things on every cycle:
- each base stays below its region size;
- a clear zeroes the bases;
- a base of zero wraps to size − 1 on rotation;
- the floating-point and predicate bases move together.

They also check that every mapping stays inside its region and that numbers below the region pass through unchanged.

Some properties can only be shown by the bench's scenarios against its reference model:
- the shift-by-one property of rotation across iterations;
- a full cycle of rotations returning to the identity;
- clamping of the general size;
- priority between clear, size write and rotation in the same cycle.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int REG_W   = 7;
    localparam int PRD_W   = 6;
    localparam int SZ_W    = 7;
    localparam int GR_LO   = 32;
    localparam int FR_LO   = 32;
    localparam int FR_SIZE = 96;
    localparam int PR_LO   = 16;
    localparam int PR_SIZE = 48;

    typedef struct packed {
        logic [SZ_W-1:0] gr_size;
    } rr_cfg_t;

    function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] req,
                                                   input int unsigned     max_sz);
        if (int'(req) > int'(max_sz)) return SZ_W'(max_sz);
        return req;
    endfunction
endpackage

// File: rtl/rr_base_ctr.sv
module rr_base_ctr #(
    parameter int SW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rot,
    input  logic          clr,
    input  logic [SW-1:0] size,
    output logic [SW-1:0] base
);
    logic [SW-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (clr)
            base_d = '0;
        else if (rot && size != '0)
            base_d = (base_q == '0) ? size - 1'b1 : base_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign base = base_q;

    // R3: a base of zero wraps to the top of the region
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rot && !clr && size != '0 && base_q == '0) |=> (base_q == SW'($past(size) - 1'b1)));

    // R4: clear zeroes the base
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (base_q == '0));

    // R2: the base always lies inside the region
    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (size != '0) |-> (base_q < size));

    // R7: an empty region keeps a zero base
    a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (size == '0) |-> (base_q == '0));
endmodule

// File: rtl/rr_map.sv
module rr_map #(
    parameter int LW = 7,
    parameter int SW = 7,
    parameter int LO = 32
) (
    input  logic [LW-1:0] lreg,
    input  logic [SW-1:0] size,
    input  logic [SW-1:0] base,
    output logic [LW-1:0] preg
);
    localparam int CW = ((LW > SW) ? LW : SW) + 2;

    logic [CW-1:0] ext, lo_c, sz_c, rel, sum, top_c;
    logic          in_rgn;

    always_comb begin
        ext    = CW'(lreg);
        lo_c   = CW'(LO);
        sz_c   = CW'(size);
        top_c  = lo_c + sz_c;
        in_rgn = (ext >= lo_c) && (ext < top_c);
        rel    = ext - lo_c;
        sum    = rel + CW'(base);
        if (sum >= sz_c)
            sum = sum - sz_c;
        preg = in_rgn ? LW'(lo_c + sum) : lreg;
    end

    always_comb begin
        // R1: numbers below the region start pass unchanged
        if (ext < lo_c)
            a_r1_below: assert (preg == lreg);
        // R2: a renamed number stays inside its region
        if (in_rgn)
            a_r2_inside: assert ((CW'(preg) >= lo_c) && (CW'(preg) < top_c));
    end
endmodule

// File: rtl/rot_rename.sv
module rot_rename
    import rr_pkg::*;
#(
    parameter int GR_MAX = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_br,
    input  logic             rrb_clear,
    input  logic             gr_size_wr,
    input  logic [SZ_W-1:0]  gr_size_in,
    input  logic [REG_W-1:0] gr_lreg,
    input  logic [REG_W-1:0] fr_lreg,
    input  logic [PRD_W-1:0] pr_lreg,
    output logic [REG_W-1:0] gr_preg,
    output logic [REG_W-1:0] fr_preg,
    output logic [PRD_W-1:0] pr_preg
);
    localparam logic [SZ_W-1:0] FR_SZ = SZ_W'(FR_SIZE);
    localparam logic [SZ_W-1:0] PR_SZ = SZ_W'(PR_SIZE);

    rr_cfg_t         cfg_d, cfg_q;
    logic [SZ_W-1:0] gr_base, fr_base, pr_base;
    logic            gr_clr;

    always_comb begin
        cfg_d = cfg_q;
        if (gr_size_wr)
            cfg_d.gr_size = clamp_size(gr_size_in, GR_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign gr_clr = rrb_clear | gr_size_wr;

    rr_base_ctr #(.SW(SZ_W)) u_gr_base (
        .clk(clk), .rst_n(rst_n), .rot(loop_br), .clr(gr_clr),
        .size(cfg_q.gr_size), .base(gr_base));

    rr_base_ctr #(.SW(SZ_W)) u_fr_base (
        .clk(clk), .rst_n(rst_n), .rot(loop_br), .clr(rrb_clear),
        .size(FR_SZ), .base(fr_base));

    rr_base_ctr #(.SW(SZ_W)) u_pr_base (
        .clk(clk), .rst_n(rst_n), .rot(loop_br), .clr(rrb_clear),
        .size(PR_SZ), .base(pr_base));

    rr_map #(.LW(REG_W), .SW(SZ_W), .LO(GR_LO)) u_gr_map (
        .lreg(gr_lreg), .size(cfg_q.gr_size), .base(gr_base), .preg(gr_preg));

    rr_map #(.LW(REG_W), .SW(SZ_W), .LO(FR_LO)) u_fr_map (
        .lreg(fr_lreg), .size(FR_SZ), .base(fr_base), .preg(fr_preg));

    rr_map #(.LW(PRD_W), .SW(SZ_W), .LO(PR_LO)) u_pr_map (
        .lreg(pr_lreg), .size(PR_SZ), .base(pr_base), .preg(pr_preg));

    // R6: floating-point and predicate bases move on the same edge
    a_r6_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_br && !rrb_clear) |=> ((fr_base != $past(fr_base)) && (pr_base != $past(pr_base))));

    // R5: the general size never exceeds the clamp limit
    a_r5_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cfg_q.gr_size) <= GR_MAX);
endmodule

// File: tb/sim_rot_rename.sv
module sim_rot_rename;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loop_br = 1'b0, rrb_clear = 1'b0, gr_size_wr = 1'b0;
    logic [6:0] gr_size_in = '0, gr_lreg = '0, fr_lreg = '0;
    logic [5:0] pr_lreg = '0;
    logic [6:0] gr_preg, fr_preg;
    logic [5:0] pr_preg;

    int n_vec = 0, n_bad = 0;
    int gbase = 0, fbase = 0, pbase = 0, gsize = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rot_rename u0 (
        .clk(clk), .rst_n(rst_n), .loop_br(loop_br), .rrb_clear(rrb_clear),
        .gr_size_wr(gr_size_wr), .gr_size_in(gr_size_in),
        .gr_lreg(gr_lreg), .fr_lreg(fr_lreg), .pr_lreg(pr_lreg),
        .gr_preg(gr_preg), .fr_preg(fr_preg), .pr_preg(pr_preg));

    function automatic int ref_map(int r, int lo, int sz, int b);
        if (r >= lo && r < lo + sz) return lo + ((r - lo + b) % sz);
        return r;
    endfunction

    function automatic int dec(int b, int sz);
        if (sz == 0) return 0;
        return (b == 0) ? sz - 1 : b - 1;
    endfunction

    task automatic check(int act, int exp, string tag);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check(int'(gr_preg), ref_map(int'(gr_lreg), 32, gsize, gbase), {tag, " gr"});
        check(int'(fr_preg), ref_map(int'(fr_lreg), 32, 96, fbase), {tag, " fr"});
        check(int'(pr_preg), ref_map(int'(pr_lreg), 16, 48, pbase), {tag, " pr"});
    endtask

    // drive at negedge, compare, then apply the edge to the model
    task automatic step(bit rot, bit clr, bit wr, int sz, int g, int f, int p, string tag);
        @(negedge clk);
        loop_br = rot; rrb_clear = clr; gr_size_wr = wr;
        gr_size_in = 7'(sz); gr_lreg = 7'(g); fr_lreg = 7'(f); pr_lreg = 6'(p);
        #2 compare(tag);
        @(posedge clk);
        if (wr) gsize = (sz > 96) ? 96 : sz;
        if (clr || wr) gbase = 0; else if (rot) gbase = dec(gbase, gsize);
        if (clr) begin fbase = 0; pbase = 0; end
        else if (rot) begin fbase = dec(fbase, 96); pbase = dec(pbase, 48); end
    endtask

    task automatic probe(int g, int f, int p, output int go, output int fo, output int po);
        @(negedge clk);
        loop_br = 0; rrb_clear = 0; gr_size_wr = 0;
        gr_lreg = 7'(g); fr_lreg = 7'(f); pr_lreg = 6'(p);
        #2 go = int'(gr_preg); fo = int'(fr_preg); po = int'(pr_preg);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int go, fo, po;
        #3;
        // R8: identity during and after reset
        check(int'(gr_preg), 0, "R8 reset gr");
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, 0, 0, 40, 100, 20, "R8 identity");

        // R1 / R2 / R3: size 8, one rotation
        step(0, 0, 1, 8, 32, 32, 16, "R5 size load");
        probe(33, 40, 17, go, fo, po);
        check(go, 33, "R2 base zero gr33");
        step(1, 0, 0, 0, 32, 32, 16, "R3 rotate");
        probe(33, 33, 17, go, fo, po);
        check(go, 32, "R3 shift gr33->32");
        check(fo, 32, "R6 shift fr33->32");
        check(po, 16, "R6 shift pr17->16");
        probe(32, 32, 16, go, fo, po);
        check(go, 39, "R3 wrap gr32");
        check(fo, 127, "R6 wrap fr32");
        check(po, 63, "R6 wrap pr16");
        probe(40, 10, 5, go, fo, po);
        check(go, 40, "R1 above region gr40");
        check(fo, 10, "R1 below fr");
        check(po, 5, "R1 below pr");

        // R3: seven more rotations bring general mapping back
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 32 + i, 50, 30, "R3 cycle");
        probe(35, 40, 20, go, fo, po);
        check(go, 35, "R3 full cycle identity");

        // R5: size write with rotate in same cycle
        step(1, 0, 1, 16, 32, 32, 16, "R5 wr+rot");
        step(0, 0, 0, 0, 47, 32, 16, "R5 after wr");
        // R4: clear overrides rotate
        step(1, 1, 0, 0, 40, 60, 30, "R4 clr+rot");
        probe(40, 60, 30, go, fo, po);
        check(go, 40, "R4 clear gr"); check(fo, 60, "R4 clear fr"); check(po, 30, "R4 clear pr");

        // R7: size zero never renames
        step(0, 0, 1, 0, 32, 32, 16, "R7 size0");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 32 + i, 32, 16, "R7 rot");
        probe(33, 32, 16, go, fo, po);
        check(go, 33, "R7 no rename");

        // R5: clamp above 96
        step(0, 0, 1, 120, 32, 32, 16, "R5 clamp");
        step(1, 0, 0, 0, 127, 32, 16, "R5 clamp rot");
        probe(32, 32, 16, go, fo, po);
        check(go, 127, "R5 clamped wrap 96");

        // R2 / R3 / R4 / R5 / R6: random traffic
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 99);
            step(sel < 60, sel >= 97, sel >= 92 && sel < 97, $urandom_range(0, 127),
                 $urandom_range(0, 127), $urandom_range(0, 127), $urandom_range(0, 63),
                 "R2 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule